// File: doc/BRIEF.md
# Washer Cycle Controller with BCD Countdown

This block runs one washer function at a time (wash, rinse or dry) for a programmed time. It drives a one-hot function vector while a minutes:seconds countdown in BCD runs down to zero. The operator sets a mode code and a four-digit BCD time while the controller is in standby. A start request launches the function, if the setting is valid. Pause freezes the countdown and switches the function off; releasing it resumes. Stop returns to standby at once, without waiting for a clock.

The countdown steps once for each cycle in which `tick` is high. A slow enable (1 Hz in a product) paces it, so the block itself runs on the system clock. The display outputs carry the stored preset and preset mode in standby, and the live count and active mode otherwise. Seven-segment decoding and key debouncing sit outside the block.

States: IDLE (standby), WASH, RINSE, DRY and HOLD (paused). Transitions:
- IDLE to WASH, RINSE or DRY when the start is accepted.
- Running to HOLD when pause is high.
- HOLD back to the function it left when pause drops.
- Running to IDLE on the terminal tick.
- Any state to IDLE on stop or reset.

Top module: `wash_cycle_ctrl`

## Requirements
- R1: `func_oh` is 001 in WASH, 010 in RINSE and 100 in DRY (bit 0 wash, bit 1 rinse, bit 2 dry), and 000 in IDLE and HOLD.
- R2: `disp_mode` shows the code of the current state while not in standby: 001 wash, 010 rinse, 011 dry, 100 paused.
- R3: In a running state with pause low, each cycle with `tick` high lowers the count by one second. The seconds-units digit wraps from 0 to 9 and borrows. The seconds-tens digit wraps from 0 to 5 and borrows. The minutes-units digit wraps from 0 to 9 and borrows. Without `tick` the count holds.
- R4: A tick at 00:01 returns the controller to IDLE at that clock edge, and `done` is high for exactly that one following cycle.
- R5: In IDLE, `start` is accepted only if the stored mode is 001, 010 or 011 and the stored time is nonzero. The function output appears one cycle after the edge on which start was sampled.
- R6: The preset inputs are captured on each clock edge taken in IDLE and never in any other state. Changing them while running or paused has no effect on the outputs.
- R7: While paused, ticks are ignored, the count is held and `disp_mode` is 100. Releasing pause resumes the same function with the held count.
- R8: A high `stop` at once forces IDLE, clears `func_oh` and `done`, and switches the display to the stored preset without waiting for a clock edge. The count is reloaded from the preset on the next edge.
- R9: A preset above 30:00 is loaded as 30:00.
- R10: In IDLE, `disp_time` and `disp_mode` show the preset time and mode captured at the previous edge.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop | input | 1 | Asynchronous stop, active high |
| tick | input | 1 | One-cycle countdown enable |
| start | input | 1 | Start request, sampled in IDLE |
| pause | input | 1 | Level-sensitive pause |
| preset_mode | input | 3 | Requested mode code |
| preset_time | input | 16 | Preset time as BCD digits {min tens, min units, sec tens, sec units} |
| disp_time | output | 16 | Displayed time, four BCD digits |
| disp_mode | output | 3 | Displayed mode code |
| func_oh | output | 3 | One-hot function drive |
| done | output | 1 | One-cycle terminal pulse |

## Verification
The assertions assume that `preset_time` carries valid BCD digits with a seconds-tens digit no larger than 5. The bench draws every digit from inside those ranges. They also assume that a stop pulse stays high across at least one rising clock edge, so that the disable condition covers any edge that the asynchronous clear could disturb. The bench holds every stop through one edge and releases it mid-cycle. The random phase mixes invalid mode codes, zero times and setting changes during runs with pause toggles and stops. Short presets keep each countdown to a few hundred cycles.

// File: rtl/wcc_pkg.sv
package wcc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WASH,
        ST_RINSE,
        ST_DRY,
        ST_HOLD
    } wcc_state_e;

    localparam logic [2:0] MC_IDLE  = 3'b000;
    localparam logic [2:0] MC_WASH  = 3'b001;
    localparam logic [2:0] MC_RINSE = 3'b010;
    localparam logic [2:0] MC_DRY   = 3'b011;
    localparam logic [2:0] MC_HOLD  = 3'b100;

    localparam int DIG_W  = 4;
    localparam int N_DIG  = 4;
    localparam int TIME_W = DIG_W * N_DIG;
endpackage

// File: rtl/wcc_setting_reg.sv
module wcc_setting_reg
    import wcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [2:0]        preset_mode,
    input  logic [TIME_W-1:0] preset_time,
    output logic [2:0]        set_mode,
    output logic [TIME_W-1:0] set_time
);
    // Settings survive a stop; only the chip reset clears them.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_mode <= MC_IDLE;
            set_time <= '0;
        end else if (capture) begin
            set_mode <= preset_mode;
            set_time <= preset_time;
        end
    end
endmodule

// File: rtl/wcc_countdown.sv
module wcc_countdown
    import wcc_pkg::*;
#(
    parameter int MAX_MIN = 30
) (
    input  logic              clk,
    input  logic              kill,
    input  logic              load,
    input  logic              dec,
    input  logic [TIME_W-1:0] preset,
    output logic [TIME_W-1:0] cnt,
    output logic              is_last
);
    localparam logic [DIG_W-1:0] MAX_TENS  = DIG_W'(MAX_MIN / 10);
    localparam logic [DIG_W-1:0] MAX_UNITS = DIG_W'(MAX_MIN % 10);
    localparam logic [6:0]       MAX_M7    = 7'(MAX_MIN);

    logic [6:0]        minutes;
    logic              secs_nz;
    logic              over;
    logic [TIME_W-1:0] clamped;
    logic [TIME_W-1:0] nxt;
    logic [N_DIG:0]    borrow;

    always_comb begin
        minutes = {3'b000, preset[4*DIG_W-1:3*DIG_W]} * 7'd10
                + {3'b000, preset[3*DIG_W-1:2*DIG_W]};
        secs_nz = preset[2*DIG_W-1:0] != '0;
        over    = (minutes > MAX_M7) || ((minutes == MAX_M7) && secs_nz);
        clamped = over ? {MAX_TENS, MAX_UNITS, {2*DIG_W{1'b0}}} : preset;
    end

    // Borrow chain: digit 1 (seconds tens) wraps to 5, the others to 9.
    assign borrow[0] = 1'b1;
    for (genvar g = 0; g < N_DIG; g++) begin : g_digit
        localparam logic [DIG_W-1:0] LIM = (g == 1) ? DIG_W'(5) : DIG_W'(9);
        logic [DIG_W-1:0] d;
        assign d = cnt[g*DIG_W +: DIG_W];
        assign nxt[g*DIG_W +: DIG_W] =
            !borrow[g]  ? d :
            (d == '0)   ? LIM : d - DIG_W'(1);
        assign borrow[g+1] = borrow[g] && (d == '0);
    end

    assign is_last = cnt == TIME_W'(1);

    always_ff @(posedge clk or posedge kill) begin
        if (kill) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= clamped;
        end else if (dec) begin
            cnt <= nxt;
        end
    end
endmodule

// File: rtl/wcc_fsm.sv
module wcc_fsm
    import wcc_pkg::*;
(
    input  logic       clk,
    input  logic       kill,
    input  logic       tick,
    input  logic       start,
    input  logic       pause,
    input  logic [2:0] set_mode,
    input  logic       time_nz,
    input  logic       cnt_last,
    output logic       load,
    output logic       dec,
    output logic [2:0] func_oh,
    output logic [2:0] mode_code,
    output logic       done
);
    wcc_state_e state, nxt, resume_q;
    logic       running;
    logic       finish;

    function automatic wcc_state_e mode_to_state(input logic [2:0] m);
        case (m)
            MC_WASH:  return ST_WASH;
            MC_RINSE: return ST_RINSE;
            MC_DRY:   return ST_DRY;
            default:  return ST_IDLE;
        endcase
    endfunction

    assign running = (state == ST_WASH) || (state == ST_RINSE) || (state == ST_DRY);
    assign finish  = running && !pause && tick && cnt_last;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start && time_nz) nxt = mode_to_state(set_mode);
            end
            ST_WASH, ST_RINSE, ST_DRY: begin
                if (pause)       nxt = ST_HOLD;
                else if (finish) nxt = ST_IDLE;
            end
            ST_HOLD: begin
                if (!pause) nxt = resume_q;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register with asynchronous stop/reset.
    always_ff @(posedge clk or posedge kill) begin
        if (kill) begin
            state    <= ST_IDLE;
            resume_q <= ST_IDLE;
            done     <= 1'b0;
        end else begin
            state <= nxt;
            done  <= finish;
            if (running) resume_q <= state;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        load      = 1'b0;
        dec       = 1'b0;
        func_oh   = 3'b000;
        mode_code = MC_IDLE;
        unique case (state)
            ST_IDLE: begin
                load = 1'b1;
            end
            ST_WASH: begin
                func_oh   = 3'b001;
                mode_code = MC_WASH;
                dec       = tick && !pause;
            end
            ST_RINSE: begin
                func_oh   = 3'b010;
                mode_code = MC_RINSE;
                dec       = tick && !pause;
            end
            ST_DRY: begin
                func_oh   = 3'b100;
                mode_code = MC_DRY;
                dec       = tick && !pause;
            end
            ST_HOLD: begin
                mode_code = MC_HOLD;
            end
            default: begin
                load = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/wcc_disp_sel.sv
module wcc_disp_sel
    import wcc_pkg::*;
(
    input  logic              show_live,
    input  logic [TIME_W-1:0] set_time,
    input  logic [2:0]        set_mode,
    input  logic [TIME_W-1:0] live_time,
    input  logic [2:0]        live_mode,
    output logic [TIME_W-1:0] disp_time,
    output logic [2:0]        disp_mode
);
    always_comb begin
        if (show_live) begin
            disp_time = live_time;
            disp_mode = live_mode;
        end else begin
            disp_time = set_time;
            disp_mode = set_mode;
        end
    end
endmodule

// File: rtl/wash_cycle_ctrl.sv
module wash_cycle_ctrl
    import wcc_pkg::*;
#(
    parameter int MAX_MIN = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stop,
    input  logic        tick,
    input  logic        start,
    input  logic        pause,
    input  logic [2:0]  preset_mode,
    input  logic [15:0] preset_time,
    output logic [15:0] disp_time,
    output logic [2:0]  disp_mode,
    output logic [2:0]  func_oh,
    output logic        done
);
    logic              kill;
    logic              idle;
    logic              dec;
    logic              cnt_last;
    logic [2:0]        set_mode;
    logic [TIME_W-1:0] set_time;
    logic [TIME_W-1:0] cnt;
    logic [2:0]        live_mode;

    assign kill = stop || !rst_n;

    wcc_setting_reg i_set (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (idle),
        .preset_mode (preset_mode),
        .preset_time (preset_time),
        .set_mode    (set_mode),
        .set_time    (set_time)
    );

    wcc_fsm i_fsm (
        .clk       (clk),
        .kill      (kill),
        .tick      (tick),
        .start     (start),
        .pause     (pause),
        .set_mode  (set_mode),
        .time_nz   (set_time != '0),
        .cnt_last  (cnt_last),
        .load      (idle),
        .dec       (dec),
        .func_oh   (func_oh),
        .mode_code (live_mode),
        .done      (done)
    );

    wcc_countdown #(.MAX_MIN(MAX_MIN)) i_cnt (
        .clk     (clk),
        .kill    (kill),
        .load    (idle),
        .dec     (dec),
        .preset  (set_time),
        .cnt     (cnt),
        .is_last (cnt_last)
    );

    wcc_disp_sel i_disp (
        .show_live (!idle),
        .set_time  (set_time),
        .set_mode  (set_mode),
        .live_time (cnt),
        .live_mode (live_mode),
        .disp_time (disp_time),
        .disp_mode (disp_mode)
    );
endmodule

// File: rtl/wcc_checker.sv
module wcc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        stop,
    input logic        tick,
    input logic        idle,
    input logic [15:0] disp_time,
    input logic [2:0]  disp_mode,
    input logic [2:0]  func_oh,
    input logic        done
);
    p_func_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n || stop)
        $onehot0(func_oh));

    p_mode_code_r2: assert property (@(posedge clk) disable iff (!rst_n || stop)
        !idle |-> (disp_mode inside {3'b001, 3'b010, 3'b011, 3'b100}));

    p_hold_count_r3: assert property (@(posedge clk) disable iff (!rst_n || stop)
        (func_oh != 3'b000 && !tick) |=> $stable(disp_time));

    p_done_standby_r4: assert property (@(posedge clk) disable iff (!rst_n || stop)
        done |-> (idle && func_oh == 3'b000));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n || stop)
        done |=> !done);

    p_pause_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n || stop)
        (!idle && func_oh == 3'b000) |=> (idle || $stable(disp_time)));

    p_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n || stop)
        !idle |-> (disp_time <= 16'h3000));
endmodule

bind wash_cycle_ctrl wcc_checker i_wcc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop      (stop),
    .tick      (tick),
    .idle      (idle),
    .disp_time (disp_time),
    .disp_mode (disp_mode),
    .func_oh   (func_oh),
    .done      (done)
);

// File: tb/test_wash_cycle_ctrl.sv
`timescale 1ns/1ps
module test_wash_cycle_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop = 1'b0;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic        pause = 1'b0;
    logic [2:0]  preset_mode = 3'd0;
    logic [15:0] preset_time = 16'h0;
    logic [15:0] disp_time;
    logic [2:0]  disp_mode;
    logic [2:0]  func_oh;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    // reference model: 0 idle, 1 run, 2 hold
    int          m_st = 0;
    int          m_fn = 0;
    int          m_secs = 0;
    logic [2:0]  m_smode = 3'd0;
    logic [15:0] m_stime = 16'h0;
    bit          m_done = 1'b0;

    always #5 clk = ~clk;

    wash_cycle_ctrl i_wash_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .stop(stop), .tick(tick), .start(start),
        .pause(pause), .preset_mode(preset_mode), .preset_time(preset_time),
        .disp_time(disp_time), .disp_mode(disp_mode), .func_oh(func_oh), .done(done)
    );

    function automatic logic [15:0] to_bcd(input int s);
        int m, ss;
        m  = s / 60;
        ss = s % 60;
        return {4'(m / 10), 4'(m % 10), 4'(ss / 10), 4'(ss % 10)};
    endfunction

    function automatic int clamp_secs(input logic [15:0] t);
        int m, s;
        m = int'(t[15:12]) * 10 + int'(t[11:8]);
        s = int'(t[7:4]) * 10 + int'(t[3:0]);
        if (m > 30 || (m == 30 && s > 0)) return 1800;
        return m * 60 + s;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare();
        int et, em, ef;
        if (m_st == 0) begin
            et = int'(m_stime); em = int'(m_smode); ef = 0;
        end else if (m_st == 1) begin
            et = int'(to_bcd(m_secs)); em = m_fn; ef = 1 << (m_fn - 1);
        end else begin
            et = int'(to_bcd(m_secs)); em = 4; ef = 0;
        end
        check("R3 disp_time", int'(disp_time), et);
        check("R2 disp_mode", int'(disp_mode), em);
        check("R1 func_oh", int'(func_oh), ef);
        check("R4 done", int'(done), int'(m_done));
    endtask

    task automatic model_edge(input bit stopped);
        logic [2:0]  om;
        logic [15:0] ot;
        om = m_smode;
        ot = m_stime;
        m_done = 1'b0;
        if (m_st == 0) begin
            m_smode = preset_mode;
            m_stime = preset_time;
        end
        if (stopped) begin
            m_st = 0;
            return;
        end
        case (m_st)
            0: begin
                m_secs = clamp_secs(ot);
                if (start && om >= 3'd1 && om <= 3'd3 && ot != 16'h0) begin
                    m_st = 1;
                    m_fn = int'(om);
                end
            end
            1: begin
                if (pause) m_st = 2;
                else if (tick) begin
                    if (m_secs == 1) begin
                        m_st = 0; m_done = 1'b1; m_secs = 0;
                    end else m_secs--;
                end
            end
            default: if (!pause) m_st = 1;
        endcase
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge(stop);
        #2;
        compare();
    endtask

    task automatic do_stop();
        #1;
        stop = 1'b1;
        #1;
        m_st = 0; m_done = 1'b0;
        // R8: asynchronous effect before any clock edge
        check("R8 func_oh after stop", int'(func_oh), 0);
        check("R8 disp_mode after stop", int'(disp_mode), int'(m_smode));
        check("R8 disp_time after stop", int'(disp_time), int'(m_stime));
        check("R8 done after stop", int'(done), 0);
        cycle();
        stop = 1'b0;
        cycle();
    endtask

    task automatic run_to_idle(input int cap);
        for (int i = 0; i < cap && m_st != 0; i++) cycle();
    endtask

    initial begin
        #1_900_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 12345;
        void'($urandom(seed));
        // R11 reset state
        repeat (3) @(posedge clk);
        #2;
        check("R11 disp_time", int'(disp_time), 0);
        check("R11 disp_mode", int'(disp_mode), 0);
        check("R11 func_oh", int'(func_oh), 0);
        check("R11 done", int'(done), 0);
        rst_n = 1'b1;
        cycle();

        // R10: preset shown one cycle after change in standby
        preset_mode = 3'd2; preset_time = 16'h0123;
        check("R10 before capture", int'(disp_time), 0);
        cycle();
        check("R10 preset time shown", int'(disp_time), 16'h0123);
        check("R10 preset mode shown", int'(disp_mode), 2);

        // R5: invalid starts
        preset_mode = 3'd0; preset_time = 16'h0010; cycle();
        start = 1'b1; cycle(); cycle();
        check("R5 mode 000 rejected", int'(func_oh), 0);
        start = 1'b0; preset_mode = 3'd5; cycle();
        start = 1'b1; cycle(); cycle();
        check("R5 mode 101 rejected", int'(func_oh), 0);
        start = 1'b0; preset_mode = 3'd1; preset_time = 16'h0000; cycle();
        start = 1'b1; cycle(); cycle();
        check("R5 zero time rejected", int'(func_oh), 0);
        start = 1'b0;

        // wash 00:12 with ticks every cycle: borrow and terminal
        preset_mode = 3'd1; preset_time = 16'h0012; cycle();
        start = 1'b1; cycle();
        start = 1'b0; cycle();
        check("R5 wash accepted", int'(func_oh), 1);
        check("R5 loaded time", int'(disp_time), 16'h0012);
        tick = 1'b1;
        cycle(); cycle(); cycle();
        check("R3 su wrap 00:10->00:09", int'(disp_time), 16'h0009);
        run_to_idle(20);
        check("R4 done pulse", int'(done), 1);
        cycle();
        check("R4 done one cycle", int'(done), 0);
        tick = 1'b0;

        // R3 tens borrow: 01:00 -> 00:59, rinse
        preset_mode = 3'd2; preset_time = 16'h0100; cycle();
        start = 1'b1; cycle(); start = 1'b0; cycle();
        tick = 1'b1; cycle(); tick = 1'b0;
        check("R3 borrow 01:00->00:59", int'(disp_time), 16'h0059);
        check("R1 rinse bit", int'(func_oh), 2);
        // R7 pause with ticks
        pause = 1'b1; tick = 1'b1; cycle(); cycle(); cycle();
        check("R7 paused mode", int'(disp_mode), 4);
        check("R7 paused time held", int'(disp_time), 16'h0059);
        check("R7 paused func off", int'(func_oh), 0);
        pause = 1'b0; tick = 1'b0; cycle();
        check("R7 resume rinse", int'(func_oh), 2);
        check("R7 resume time", int'(disp_time), 16'h0059);
        // R6 settings ignored while running
        preset_mode = 3'd3; preset_time = 16'h0005; cycle(); cycle();
        check("R6 func unchanged", int'(func_oh), 2);
        check("R6 time unchanged", int'(disp_time), 16'h0059);
        // R8 stop
        do_stop();
        check("R8 reload shows preset", int'(disp_time), 16'h0005);
        start = 1'b1; cycle(); start = 1'b0; cycle();
        check("R8 restart dry", int'(func_oh), 4);
        check("R8 restart full time", int'(disp_time), 16'h0005);
        do_stop();

        // R9 clamp
        preset_mode = 3'd3; preset_time = 16'h4530; cycle();
        start = 1'b1; cycle(); start = 1'b0; cycle();
        check("R9 clamp 45:30", int'(disp_time), 16'h3000);
        tick = 1'b1; cycle(); tick = 1'b0;
        check("R9 clamp then tick", int'(disp_time), 16'h2959);
        do_stop();
        preset_time = 16'h3020; cycle();
        start = 1'b1; cycle(); start = 1'b0; cycle();
        check("R9 clamp 30:20", int'(disp_time), 16'h3000);
        do_stop();

        // constrained random runs
        for (int r = 0; r < 300; r++) begin
            int pm, r2;
            pm = int'($urandom_range(0, 9));
            preset_mode = (pm < 7) ? 3'(1 + pm % 3) : 3'(pm == 7 ? 0 : 4 + pm % 4);
            preset_time = {4'd0, 4'($urandom_range(0, 1)), 4'($urandom_range(0, 5)),
                           4'($urandom_range(0, 9))};
            cycle();
            start = 1'b1; cycle(); start = 1'b0;
            for (int c = 0; c < 400 && m_st != 0; c++) begin
                r2 = int'($urandom_range(0, 99));
                tick = (r2 < 75);
                if (r2 < 5) pause = ~pause;
                if (r2 == 50) preset_time = {4'd0, 4'd0, 4'($urandom_range(0, 5)), 4'd1};
                if (r2 == 51) preset_mode = 3'($urandom_range(0, 7));
                if (r2 == 99 && $urandom_range(0, 9) == 0) begin
                    tick = 1'b0; pause = 1'b0;
                    do_stop();
                end else cycle();
            end
            pause = 1'b0; tick = 1'b0;
            cycle();
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule